// File: doc/BRIEF.md
# Inter-Core Send Command Dispatcher

This block takes 64-bit send commands that any core writes into a small command window and turns each one into an action on the register bank of one target core. A command word carries everything the action needs: the target core number, an interrupt vector or mailbox slot or register address, a four-bit byte-preserve mask and a 32-bit replacement word. The block does not hold the per-core registers itself. It drives a shared target port that the surrounding logic routes to the selected core's bank.

There are three kinds of command. An interrupt send is a 32-bit write. It asks the target's status register to set the single bit selected by the vector. A mailbox send is a 64-bit write. It stores into one of eight mailbox words of the target. A register send is a 64-bit write. It stores into any 16-bit register address of the target. Both store kinds honour the byte-preserve mask. When the mask is clear, the word is written straight away. When any mask bit is set, a read-modify-write is sequenced: read the old word, wait for it, merge it, then write. The dispatcher reports busy for the whole sequence. A target number with no core behind it raises a one-cycle decode error, and nothing is sent to any bank.

Top module: `ipi_send_dispatch`

## Requirements
- R1: The target core number is command bits [25:16]. A recognised command whose core number is NUM_CORES or higher pulses decode_err for exactly one cycle, in the cycle after acceptance. In that case no read, write or set is issued and busy stays low.
- R2: An interrupt send is a 32-bit write (cmd_is64=0) at offset 0x040. In the cycle after acceptance it pulses tgt_set_en for one cycle, with tgt_set_mask = 1 << cmd_data[4:0] and tgt_core equal to the target. Command bits [63:32] play no part.
- R3: A mailbox send is a 64-bit write at offset 0x108. It targets the address 0x20 + (cmd_data & 0x1C), which is one of eight words spaced four bytes apart. The other low command bits do not change the address.
- R4: A register send is a 64-bit write at offset 0x110. It targets the address cmd_data[15:0].
- R5: When the byte-preserve mask cmd_data[30:27] is zero, no read is issued. The full word cmd_data[63:32] is written with tgt_wr_en in the cycle after acceptance.
- R6: When the mask is nonzero, tgt_rd_req pulses in the cycle after acceptance. The block then waits for tgt_rd_valid. In the cycle after the read data arrives it writes a merged word: byte i keeps the old value when mask bit i (command bit 27+i) is 1, and takes byte i of cmd_data[63:32] when that bit is 0.
- R7: For a store command, busy is high from the cycle after acceptance up to and including the write cycle, and low in the cycle after. Commands presented while busy is high are ignored. Target core and address stay stable while busy.
- R8: Any other offset, or a recognised offset with the wrong width, has no effect. No action output pulses, busy stays low and no error is reported.
- R9: While rst_n is low, busy, decode_err, tgt_set_en, tgt_rd_req and tgt_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command write is presented this cycle |
| cmd_is64 | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| cmd_offset | input | OFFS_W | Byte offset of the write within the command window |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | A store sequence is in progress; new commands are ignored |
| decode_err | output | 1 | One-cycle pulse: the target core does not exist |
| tgt_core | output | 10 | Target core of the current action |
| tgt_addr | output | 16 | Target register address for read and write |
| tgt_set_en | output | 1 | One-cycle pulse: OR tgt_set_mask into the target's status |
| tgt_set_mask | output | 32 | Single-bit status set mask |
| tgt_rd_req | output | 1 | One-cycle read request to the target bank |
| tgt_rd_valid | input | 1 | Read data from the target bank is valid |
| tgt_rd_data | input | 32 | Read data from the target bank |
| tgt_wr_en | output | 1 | One-cycle write strobe to the target bank |
| tgt_wr_data | output | 32 | Word to write |

## Verification
The assertions assume that the target bank answers each read request with exactly one tgt_rd_valid pulse. That pulse must come no earlier than the cycle after the request and before any other read is requested. They also assume that read data outside a read sequence is never presented. The bench acts as the target bank and keeps within these limits. It watches for tgt_rd_req and drives a single response after a chosen latency of one to four cycles, and it never drives tgt_rd_valid at any other time. Commands presented during busy are driven only while the sequencer waits for read data, so that they cannot coincide with acceptance of a legitimate command.

// File: rtl/ipi_disp_pkg.sv
// Package: shared constants, field positions and enumerations for the
// inter-core send command dispatcher.
package ipi_disp_pkg;
    localparam int CMD_W     = 64;
    localparam int WORD_W    = 32;
    localparam int BYTES     = WORD_W / 8;
    localparam int CORE_W    = 10;
    localparam int CORE_LSB  = 16;
    localparam int KEEP_LSB  = 27;
    localparam int NEW_LSB   = 32;
    localparam int TADDR_W   = 16;
    localparam int VEC_W     = 5;
    localparam int SLOT_LSB  = 2;
    localparam int SLOT_W    = 3;

    localparam logic [TADDR_W-1:0] MBOX_BASE = 16'h0020;

    localparam int OFF_IRQ  = 'h040;
    localparam int OFF_MBOX = 'h108;
    localparam int OFF_REG  = 'h110;

    typedef enum logic [1:0] {
        K_NONE,
        K_IRQ,
        K_MBOX,
        K_REG
    } cmd_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WAIT,
        S_WRITE
    } seq_state_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
// Module: ipi_cmd_decode
// Purely combinational decode of one command write into its kind, target
// core, target address, byte-preserve mask, replacement word and status set
// mask. It assumes the offset is already local to the command window.
// Width mismatches make a command unrecognised (K_NONE).
module ipi_cmd_decode
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int OFFS_W    = 9
) (
    input  logic                 cmd_is64,
    input  logic [OFFS_W-1:0]    cmd_offset,
    input  logic [CMD_W-1:0]     cmd_data,
    output cmd_kind_t            kind,
    output logic [CORE_W-1:0]    core_id,
    output logic                 core_ok,
    output logic [TADDR_W-1:0]   taddr,
    output logic [BYTES-1:0]     keep,
    output logic [WORD_W-1:0]    new_word,
    output logic [WORD_W-1:0]    vec_mask
);
    localparam logic [OFFS_W-1:0] O_IRQ  = OFFS_W'(OFF_IRQ);
    localparam logic [OFFS_W-1:0] O_MBOX = OFFS_W'(OFF_MBOX);
    localparam logic [OFFS_W-1:0] O_REG  = OFFS_W'(OFF_REG);

    logic [TADDR_W-1:0] mbox_addr;
    logic [VEC_W-1:0]   vec;
    logic               unused_bits;

    // Bits that carry no meaning for any command kind.
    assign unused_bits = ^{cmd_data[KEEP_LSB+BYTES], cmd_data[KEEP_LSB-1]};

    // Field extraction shared by every kind.
    assign core_id  = cmd_data[CORE_LSB +: CORE_W];
    assign core_ok  = 32'(core_id) < NUM_CORES;
    assign keep     = cmd_data[KEEP_LSB +: BYTES];
    assign new_word = cmd_data[NEW_LSB +: WORD_W];
    assign vec      = cmd_data[VEC_W-1:0];
    assign vec_mask = WORD_W'(1) << vec;

    // Mailbox slot selects one of eight words above the mailbox base.
    assign mbox_addr = MBOX_BASE
                     + {{(TADDR_W-SLOT_W-SLOT_LSB){1'b0}},
                        cmd_data[SLOT_LSB +: SLOT_W], {SLOT_LSB{1'b0}}};

    // Kind selection from offset and access width.
    always_comb begin
        kind = K_NONE;
        if (cmd_offset == O_IRQ && !cmd_is64)      kind = K_IRQ;
        else if (cmd_offset == O_MBOX && cmd_is64) kind = K_MBOX;
        else if (cmd_offset == O_REG && cmd_is64)  kind = K_REG;
    end

    // Target address: mailbox word or raw register address.
    always_comb begin
        taddr = cmd_data[TADDR_W-1:0];
        if (kind == K_MBOX) taddr = mbox_addr;
    end
endmodule

// File: rtl/ipi_byte_merge.sv
// Module: ipi_byte_merge
// Combinational per-byte select between an old word and a new word. A set
// keep bit preserves the old byte; a clear one takes the new byte.
module ipi_byte_merge #(
    parameter int BYTES = 4
) (
    input  logic [BYTES-1:0]   keep,
    input  logic [8*BYTES-1:0] old_word,
    input  logic [8*BYTES-1:0] new_word,
    output logic [8*BYTES-1:0] merged
);
    // One byte lane per keep bit.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8]
                                          : new_word[8*b +: 8];
    end
endmodule

// File: rtl/ipi_seq_fsm.sv
// Module: ipi_seq_fsm
// Store sequencer. It leaves IDLE on a store start, issues a one-cycle read
// when a merge is needed, waits for read data, and then issues a one-cycle
// write. It assumes that exactly one read response arrives per read request.
module ipi_seq_fsm
    import ipi_disp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_read,
    input  logic rd_valid,
    output logic busy,
    output logic rd_req,
    output logic wr_en,
    output logic capture
);
    seq_state_t state;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (start) state <= need_read ? S_READ : S_WRITE;
                S_READ:  state <= S_WAIT;
                S_WAIT:  if (rd_valid) state <= S_WRITE;
                S_WRITE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Strobes decoded from the current state.
    assign busy    = state != S_IDLE;
    assign rd_req  = state == S_READ;
    assign wr_en   = state == S_WRITE;
    assign capture = (state == S_WAIT) && rd_valid;
endmodule

// File: rtl/ipi_send_dispatch.sv
// Module: ipi_send_dispatch (top)
// Accepts command writes while idle, decodes them, and drives one shared
// target port. Interrupt sends and decode errors are one-cycle pulses in
// the cycle after acceptance. Stores go through the sequencer. Commands seen
// while busy are dropped. The surrounding logic routes the target port to
// the bank of tgt_core.
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int OFFS_W    = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is64,
    input  logic [OFFS_W-1:0]    cmd_offset,
    input  logic [CMD_W-1:0]     cmd_data,
    output logic                 busy,
    output logic                 decode_err,
    output logic [CORE_W-1:0]    tgt_core,
    output logic [TADDR_W-1:0]   tgt_addr,
    output logic                 tgt_set_en,
    output logic [WORD_W-1:0]    tgt_set_mask,
    output logic                 tgt_rd_req,
    input  logic                 tgt_rd_valid,
    input  logic [WORD_W-1:0]    tgt_rd_data,
    output logic                 tgt_wr_en,
    output logic [WORD_W-1:0]    tgt_wr_data
);
    cmd_kind_t            d_kind;
    logic [CORE_W-1:0]    d_core;
    logic                 d_core_ok;
    logic [TADDR_W-1:0]   d_addr;
    logic [BYTES-1:0]     d_keep;
    logic [WORD_W-1:0]    d_new;
    logic [WORD_W-1:0]    d_vec_mask;

    logic                 accept;
    logic                 start_store;
    logic                 capture;
    logic [BYTES-1:0]     keep_q;
    logic [WORD_W-1:0]    data_q;
    logic [WORD_W-1:0]    merged;

    ipi_cmd_decode #(
        .NUM_CORES (NUM_CORES),
        .OFFS_W    (OFFS_W)
    ) dec_i (
        .cmd_is64   (cmd_is64),
        .cmd_offset (cmd_offset),
        .cmd_data   (cmd_data),
        .kind       (d_kind),
        .core_id    (d_core),
        .core_ok    (d_core_ok),
        .taddr      (d_addr),
        .keep       (d_keep),
        .new_word   (d_new),
        .vec_mask   (d_vec_mask)
    );

    // A command is taken only while idle and only if its kind is recognised.
    assign accept      = cmd_valid && !busy && (d_kind != K_NONE);
    assign start_store = accept && d_core_ok && (d_kind != K_IRQ);

    ipi_seq_fsm seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_store),
        .need_read (|d_keep),
        .rd_valid  (tgt_rd_valid),
        .busy      (busy),
        .rd_req    (tgt_rd_req),
        .wr_en     (tgt_wr_en),
        .capture   (capture)
    );

    ipi_byte_merge #(
        .BYTES (BYTES)
    ) mrg_i (
        .keep     (keep_q),
        .old_word (tgt_rd_data),
        .new_word (data_q),
        .merged   (merged)
    );

    // One-cycle pulses for interrupt sends and unknown targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decode_err <= 1'b0;
            tgt_set_en <= 1'b0;
        end else begin
            decode_err <= accept && !d_core_ok;
            tgt_set_en <= accept && d_core_ok && (d_kind == K_IRQ);
        end
    end

    // Latch the decoded fields of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_core     <= '0;
            tgt_addr     <= '0;
            tgt_set_mask <= '0;
            keep_q       <= '0;
        end else if (accept) begin
            tgt_core     <= d_core;
            tgt_addr     <= d_addr;
            tgt_set_mask <= d_vec_mask;
            keep_q       <= d_keep;
        end
    end

    // Write word: the new word on accept, replaced by the merge on read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (accept)  data_q <= d_new;
        else if (capture) data_q <= merged;
    end

    assign tgt_wr_data = data_q;
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
// Module: ipi_send_dispatch_chk
// Assertion checker bound to the dispatcher top. It relates the action
// outputs over time and assumes the target bank protocol in the brief.
module ipi_send_dispatch_chk
    import ipi_disp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               decode_err,
    input logic               tgt_set_en,
    input logic [WORD_W-1:0]  tgt_set_mask,
    input logic               tgt_rd_req,
    input logic               tgt_wr_en,
    input logic [CORE_W-1:0]  tgt_core,
    input logic [TADDR_W-1:0] tgt_addr
);
    // R7: at most one action on the target port per cycle.
    p_one_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_rd_req, tgt_wr_en, tgt_set_en, decode_err}));

    // R6: a read request is followed by waiting, still busy, with no write.
    p_read_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_req |=> (busy && !tgt_rd_req && !tgt_wr_en));

    // R7: the write cycle ends the busy period.
    p_write_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_en |=> !busy);

    // R7: writes only happen inside a busy period.
    p_write_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_en |-> busy);

    // R1: an unknown target starts no store sequence.
    p_err_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> !busy);

    // R2: an interrupt send sets exactly one status bit.
    p_set_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_set_en |-> ($countones(tgt_set_mask) == 1));

    // R7: target core and address hold steady through a store sequence.
    p_target_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(tgt_addr) && $stable(tgt_core)));
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .decode_err   (decode_err),
    .tgt_set_en   (tgt_set_en),
    .tgt_set_mask (tgt_set_mask),
    .tgt_rd_req   (tgt_rd_req),
    .tgt_wr_en    (tgt_wr_en),
    .tgt_core     (tgt_core),
    .tgt_addr     (tgt_addr)
);

// File: tb/ipi_send_dispatch_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every vector on every core, every mailbox slot with every
// byte mask, a spread of register addresses, unknown targets and ignored
// offsets. It plays the target bank, and expected values are computed here.
module ipi_send_dispatch_tb_top;
    localparam int NC     = 4;
    localparam int OFFS_W = 9;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic              cmd_is64;
    logic [OFFS_W-1:0] cmd_offset;
    logic [63:0]       cmd_data;
    logic              busy;
    logic              decode_err;
    logic [9:0]        tgt_core;
    logic [15:0]       tgt_addr;
    logic              tgt_set_en;
    logic [31:0]       tgt_set_mask;
    logic              tgt_rd_req;
    logic              tgt_rd_valid;
    logic [31:0]       tgt_rd_data;
    logic              tgt_wr_en;
    logic [31:0]       tgt_wr_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(NC), .OFFS_W(OFFS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is64(cmd_is64),
        .cmd_offset(cmd_offset), .cmd_data(cmd_data), .busy(busy),
        .decode_err(decode_err), .tgt_core(tgt_core), .tgt_addr(tgt_addr),
        .tgt_set_en(tgt_set_en), .tgt_set_mask(tgt_set_mask),
        .tgt_rd_req(tgt_rd_req), .tgt_rd_valid(tgt_rd_valid),
        .tgt_rd_data(tgt_rd_data), .tgt_wr_en(tgt_wr_en),
        .tgt_wr_data(tgt_wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] old_word(input int core,
                                             input logic [15:0] a);
        return 32'h9E3779B9 ^ (32'(core) << 24) ^ (32'(a) * 32'h00010001);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] od,
                                          input logic [31:0] nw,
                                          input logic [3:0] keep);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = keep[i] ? od[8*i +: 8] : nw[8*i +: 8];
        return r;
    endfunction

    // Command word: new[63:32], keep[30:27], core[25:16], low[15:0].
    function automatic logic [63:0] mk_cmd(input logic [31:0] nw,
                                           input logic [3:0] keep,
                                           input logic [9:0] core,
                                           input logic [15:0] low);
        return {nw, 1'b0, keep, 1'b0, core, low};
    endfunction

    task automatic issue(input logic [OFFS_W-1:0] off, input logic is64,
                         input logic [63:0] d);
        cmd_offset = off;
        cmd_is64   = is64;
        cmd_data   = d;
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    // All action outputs and busy low.
    task automatic idle_check(input string tag);
        chk(tag, {59'd0, busy, tgt_rd_req, tgt_wr_en, tgt_set_en, decode_err},
            64'd0);
    endtask

    task automatic do_irq(input int core, input int vec);
        issue(9'h040, 1'b0, mk_cmd(32'hDEAD0000 ^ 32'(vec), 4'hF,
                                   10'(core), 16'(vec)));
        chk("R2 set_en", tgt_set_en, 1);
        chk("R2 set_mask", tgt_set_mask, 64'(32'd1 << vec));
        chk("R2 core", tgt_core, core);
        chk("R2 no store/err", {busy, tgt_rd_req, tgt_wr_en, decode_err}, 0);
        @(negedge clk);
        chk("R2 single pulse", tgt_set_en, 0);
    endtask

    task automatic do_bad(input logic [OFFS_W-1:0] off, input logic is64,
                          input int core);
        issue(off, is64, mk_cmd(32'h12345678, 4'h0, 10'(core), 16'h0004));
        chk("R1 decode_err", decode_err, 1);
        chk("R1 no action", {busy, tgt_rd_req, tgt_wr_en, tgt_set_en}, 0);
        @(negedge clk);
        idle_check("R1 err single pulse");
    endtask

    task automatic do_store(input string tag, input logic [OFFS_W-1:0] off,
                            input int core, input logic [15:0] low,
                            input logic [3:0] keep, input logic [31:0] nw,
                            input logic [15:0] exp_addr, input int lat,
                            input bit poke);
        issue(off, 1'b1, mk_cmd(nw, keep, 10'(core), low));
        chk({tag, " addr"}, tgt_addr, exp_addr);
        chk({tag, " core"}, tgt_core, core);
        chk("R7 busy", busy, 1);
        if (keep == 4'h0) begin
            chk("R5 direct write", {tgt_rd_req, tgt_wr_en}, 2'b01);
            chk("R5 full word", tgt_wr_data, nw);
        end else begin
            chk("R6 read first", {tgt_rd_req, tgt_wr_en}, 2'b10);
            @(negedge clk);
            if (poke) begin
                cmd_offset = 9'h040;
                cmd_is64   = 1'b0;
                cmd_data   = mk_cmd(32'h0, 4'h0, 10'd0, 16'd3);
                cmd_valid  = 1'b1;
            end
            for (int i = 0; i < lat; i++) begin
                chk("R6 waiting", {busy, tgt_rd_req, tgt_wr_en}, 3'b100);
                @(negedge clk);
            end
            cmd_valid    = 1'b0;
            tgt_rd_valid = 1'b1;
            tgt_rd_data  = old_word(core, exp_addr);
            @(negedge clk);
            tgt_rd_valid = 1'b0;
            chk("R6 merged write", tgt_wr_en, 1);
            chk("R6 merged data", tgt_wr_data,
                merge(old_word(core, exp_addr), nw, keep));
            chk({tag, " addr at write"}, tgt_addr, exp_addr);
        end
        @(negedge clk);
        idle_check(poke ? "R7 busy command ignored" : "R7 release");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors",
                     checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        cmd_valid    = 1'b0;
        cmd_is64     = 1'b0;
        cmd_offset   = '0;
        cmd_data     = '0;
        tgt_rd_valid = 1'b0;
        tgt_rd_data  = '0;
        repeat (3) @(negedge clk);
        idle_check("R9 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R9 after reset");

        // R2: every vector on every core.
        for (int c = 0; c < NC; c++)
            for (int v = 0; v < 32; v++)
                do_irq(c, v);

        // R1: unknown targets for every command kind.
        do_bad(9'h040, 1'b0, NC);
        do_bad(9'h108, 1'b1, NC);
        do_bad(9'h110, 1'b1, 1023);
        do_bad(9'h040, 1'b0, 600);

        // R3, R5, R6: every slot with every byte mask.
        for (int s = 0; s < 8; s++)
            for (int k = 0; k < 16; k++)
                do_store("R3", 9'h108, s % NC,
                         16'(s << 2) | 16'hA5E3 & 16'hFFE3,
                         4'(k), 32'h11223344 ^ (32'(s * 16 + k) * 32'h01010101),
                         16'h0020 + 16'(s * 4), (k % 4) + 1, k == 5);

        // R4: spread of raw register addresses and masks.
        for (int a = 0; a < 6; a++)
            for (int k = 0; k < 16; k += 3) begin
                logic [15:0] ad;
                case (a)
                    0: ad = 16'h0000;
                    1: ad = 16'h0048;
                    2: ad = 16'h1234;
                    3: ad = 16'hFFFC;
                    4: ad = 16'hBEEF;
                    default: ad = 16'h8001;
                endcase
                do_store("R4", 9'h110, (a + k) % NC, ad, 4'(k),
                         32'hCAFEF00D ^ 32'(a * 77 + k), ad, (a % 3) + 1, 1'b0);
            end

        // R8: wrong width or unknown offset does nothing.
        issue(9'h040, 1'b1, mk_cmd(32'h1, 4'h0, 10'd1, 16'd4));
        idle_check("R8 irq offset as 64-bit");
        issue(9'h108, 1'b0, mk_cmd(32'h1, 4'h0, 10'd1, 16'd4));
        idle_check("R8 mailbox offset as 32-bit");
        issue(9'h110, 1'b0, mk_cmd(32'h1, 4'h3, 10'd1, 16'd4));
        idle_check("R8 register offset as 32-bit");
        issue(9'h100, 1'b1, mk_cmd(32'h1, 4'h0, 10'd1, 16'd4));
        idle_check("R8 offset 0x100");
        issue(9'h118, 1'b1, mk_cmd(32'h1, 4'h0, 10'd1, 16'd4));
        idle_check("R8 offset 0x118");
        issue(9'h044, 1'b0, mk_cmd(32'h1, 4'h0, 10'd900, 16'd4));
        idle_check("R8 offset 0x044 with bad core");
        @(negedge clk);
        idle_check("R8 still idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule